// File: doc/BRIEF.md
# Receiver Gain-Settling Handshake Controller

This controller runs the receive gain-control sequence from one request line. A rising edge on the request starts a settling cycle. The completion flag drops at once and rises again when the settle timer runs out. At that point the gain code taken from the gain loop is latched, capped at the stored ceiling. The loop is modelled here as the `loop_gain` input.

The request line has a second meaning, set by how long it stays high. If it falls again within one microsecond of its rising edge, no settle is reported. Instead the gain jumps to the programmed ceiling, the channel-filter corner moves to its 1 MHz low cut-off setting, and a fixed three-microsecond recovery interval runs. Both time windows are counted in reference-clock cycles derived from `CLK_MHZ`.

The ceiling register can be written from 54 to 85. Only a manual-gain override can drive a code above it, and nothing the sequencer does changes the stored ceiling.

Top module: `agc_handshake`

## Requirements
- R1: After reset `done`=0, `settling`=0, `filt_lo`=0, `gmax_val`=85 and `gain_code`=85.
- R2: With `rx_mode`=1, a 0-to-1 change on `agc_req` drives `done` to 0 and `settling` to 1 on the third clock edge after the change is sampled (two synchroniser stages plus one register).
- R3: A normal cycle lasts SETTLE_CYC edges. On its last edge `done` rises, `settling` falls and the held gain becomes min(`loop_gain`, `gmax_val`). `gain_code` shows that gain one edge later.
- R4: A request that is high for at most SHORT_CYC = CLK_MHZ clock cycles causes a forced-maximum event. The held gain becomes `gmax_val`, `filt_lo` becomes 1, `done` stays 0, and `settling` stays high for FORCE_CYC = 3*CLK_MHZ edges.
- R5: If the request falls after the short window, the fall has no effect, and the normal cycle finishes on time with `done`=1.
- R6: Every normal start clears `filt_lo` to 0. `done` and `filt_lo` are never 1 together.
- R7: A write with `gmax_we`=1 stores `gmax_wdata` clamped to the range 54..85. The stored value appears on `gmax_val` one edge later.
- R8: `gmax_val` changes only on a write. Settling cycles, forced-maximum events and manual mode leave it unchanged.
- R9: While `manual_en`=1, `gain_code` equals `manual_gain` one edge later, without clamping, even above the ceiling. Clearing `manual_en` returns `gain_code` to the held gain.
- R10: A rising edge during a cycle restarts the count from zero, and `done` stays 0 until the restarted cycle completes.
- R11: While `rx_mode`=0, request edges are ignored. Dropping `rx_mode` mid-cycle ends the cycle with `settling`=0 and leaves `done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode | input | 1 | High while the receiver is in receive mode |
| agc_req | input | 1 | Asynchronous settle / force request |
| gmax_we | input | 1 | Ceiling register write enable |
| gmax_wdata | input | GAIN_W | Ceiling write data, clamped on store |
| manual_en | input | 1 | Manual gain override enable |
| manual_gain | input | GAIN_W | Manual gain code |
| loop_gain | input | GAIN_W | Gain code reached by the gain loop |
| gain_code | output | GAIN_W | Registered gain code to the gain stages |
| gmax_val | output | GAIN_W | Stored gain ceiling |
| done | output | 1 | Settle-complete status |
| settling | output | 1 | High during a settle or forced recovery |
| filt_lo | output | 1 | 1 selects the 1 MHz low filter corner |

## Verification
The bench builds the block with CLK_MHZ=8 and SETTLE_CYC=40, so the short window is 8 cycles and the forced recovery is 24 cycles. This makes it practical to sweep every request width from 1 to 12 cycles across the short/long boundary. It also writes all 128 possible ceiling codes, covering both clamp limits, and spreads the loop gain over the full code range against a lowered ceiling. With these short windows, restart, receive-mode abort and manual override can each be timed to the exact edge.

// File: rtl/agc_hs_pkg.sv
package agc_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_FORCE  = 2'd2
  } seq_state_t;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/agc_req_sync.sv
module agc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_rise,
  output logic req_fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], req_async};
  end

  assign req_rise = chain[STAGES-1] & ~chain[STAGES];
  assign req_fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/agc_gmax_reg.sv
module agc_gmax_reg
  import agc_hs_pkg::*;
#(
  parameter int GAIN_W  = 7,
  parameter int GMAX_LO = 54,
  parameter int GMAX_HI = 85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] ceiling
);
  always_ff @(posedge clk) begin
    if (rst)        ceiling <= GAIN_W'(GMAX_HI);
    else if (wr_en) ceiling <= GAIN_W'(clamp_int(int'(wr_data), GMAX_LO, GMAX_HI));
  end
endmodule

// File: rtl/agc_seq_ctrl.sv
module agc_seq_ctrl
  import agc_hs_pkg::*;
#(
  parameter int GAIN_W     = 7,
  parameter int GAIN_RST   = 85,
  parameter int SHORT_CYC  = 250,
  parameter int FORCE_CYC  = 750,
  parameter int SETTLE_CYC = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_mode,
  input  logic              req_rise,
  input  logic              req_fall,
  input  logic [GAIN_W-1:0] loop_gain,
  input  logic [GAIN_W-1:0] ceiling,
  output logic              done,
  output logic              settling,
  output logic              filt_lo,
  output logic [GAIN_W-1:0] held_gain
);
  localparam int MAX_CYC = (SETTLE_CYC > FORCE_CYC) ? SETTLE_CYC : FORCE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [GAIN_W-1:0] capped;

  assign capped = (loop_gain > ceiling) ? ceiling : loop_gain;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      settling  <= 1'b0;
      filt_lo   <= 1'b0;
      held_gain <= GAIN_W'(GAIN_RST);
    end else if (!rx_mode) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      settling <= 1'b0;
    end else if (req_rise) begin
      st       <= ST_SETTLE;
      cnt      <= '0;
      done     <= 1'b0;
      settling <= 1'b1;
      filt_lo  <= 1'b0;
    end else begin
      case (st)
        ST_SETTLE: begin
          if (req_fall && (cnt < CNT_W'(SHORT_CYC))) begin
            st        <= ST_FORCE;
            cnt       <= '0;
            held_gain <= ceiling;
            filt_lo   <= 1'b1;
          end else if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            done      <= 1'b1;
            settling  <= 1'b0;
            held_gain <= capped;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FORCE: begin
          if (cnt == CNT_W'(FORCE_CYC - 1)) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            settling <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/agc_handshake.sv
module agc_handshake #(
  parameter int GAIN_W      = 7,
  parameter int GMAX_LO     = 54,
  parameter int GMAX_HI     = 85,
  parameter int CLK_MHZ     = 250,
  parameter int SETTLE_CYC  = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_mode,
  input  logic              agc_req,
  input  logic              gmax_we,
  input  logic [GAIN_W-1:0] gmax_wdata,
  input  logic              manual_en,
  input  logic [GAIN_W-1:0] manual_gain,
  input  logic [GAIN_W-1:0] loop_gain,
  output logic [GAIN_W-1:0] gain_code,
  output logic [GAIN_W-1:0] gmax_val,
  output logic              done,
  output logic              settling,
  output logic              filt_lo
);
  localparam int SHORT_CYC = CLK_MHZ;
  localparam int FORCE_CYC = 3 * CLK_MHZ;

  logic              req_rise;
  logic              req_fall;
  logic [GAIN_W-1:0] held_gain;

  agc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_async(agc_req),
    .req_rise(req_rise), .req_fall(req_fall)
  );

  agc_gmax_reg #(.GAIN_W(GAIN_W), .GMAX_LO(GMAX_LO), .GMAX_HI(GMAX_HI)) u_gmax (
    .clk(clk), .rst(rst), .wr_en(gmax_we), .wr_data(gmax_wdata), .ceiling(gmax_val)
  );

  agc_seq_ctrl #(
    .GAIN_W(GAIN_W), .GAIN_RST(GMAX_HI), .SHORT_CYC(SHORT_CYC),
    .FORCE_CYC(FORCE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .req_rise(req_rise), .req_fall(req_fall),
    .loop_gain(loop_gain), .ceiling(gmax_val), .done(done), .settling(settling),
    .filt_lo(filt_lo), .held_gain(held_gain)
  );

  always_ff @(posedge clk) begin
    if (rst)            gain_code <= GAIN_W'(GMAX_HI);
    else if (manual_en) gain_code <= manual_gain;
    else                gain_code <= held_gain;
  end
endmodule

// File: rtl/agc_handshake_chk.sv
module agc_handshake_chk #(
  parameter int GAIN_W  = 7,
  parameter int GMAX_LO = 54,
  parameter int GMAX_HI = 85
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_mode,
  input logic              gmax_we,
  input logic [GAIN_W-1:0] gmax_val,
  input logic              done,
  input logic              settling,
  input logic              filt_lo
);
  // R7
  gmax_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(gmax_val) >= GMAX_LO) && (int'(gmax_val) <= GMAX_HI));

  // R8
  gmax_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gmax_we) |-> $stable(gmax_val));

  // R6
  done_filt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && filt_lo));

  // R3
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(settling));

  // R10
  busy_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    settling |-> !done);

  // R11
  rx_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_mode |=> !settling);
endmodule

bind agc_handshake agc_handshake_chk #(
  .GAIN_W(GAIN_W), .GMAX_LO(GMAX_LO), .GMAX_HI(GMAX_HI)
) u_chk (
  .clk(clk), .rst(rst), .rx_mode(rx_mode), .gmax_we(gmax_we), .gmax_val(gmax_val),
  .done(done), .settling(settling), .filt_lo(filt_lo)
);

// File: tb/agc_handshake_tb.sv
`timescale 1ns/1ps
module agc_handshake_tb;
  localparam int GW = 7;
  localparam int MHZ = 8;
  localparam int S = 40;
  localparam int SHORT = MHZ;
  localparam int F = 3 * MHZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_mode = 1'b1;
  logic agc_req = 1'b0;
  logic gmax_we = 1'b0;
  logic [GW-1:0] gmax_wdata = '0;
  logic manual_en = 1'b0;
  logic [GW-1:0] manual_gain = '0;
  logic [GW-1:0] loop_gain = '0;
  logic [GW-1:0] gain_code, gmax_val;
  logic done, settling, filt_lo;

  int checks = 0;
  int fails = 0;
  int gm = 85;

  always #2 clk = ~clk;

  agc_handshake #(.GAIN_W(GW), .CLK_MHZ(MHZ), .SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .agc_req(agc_req),
    .gmax_we(gmax_we), .gmax_wdata(gmax_wdata), .manual_en(manual_en),
    .manual_gain(manual_gain), .loop_gain(loop_gain), .gain_code(gain_code),
    .gmax_val(gmax_val), .done(done), .settling(settling), .filt_lo(filt_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One request pulse of w cycles from idle, with the loop gain lg.
  task automatic run_pulse(input int w, input int lg);
    bit short_p;
    int total;
    short_p = (w <= SHORT);
    total = short_p ? (4 + w + F) : (4 + S);
    loop_gain = GW'(lg);
    @(negedge clk);
    agc_req = 1'b1;
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      if (n == w) agc_req = 1'b0;
      if (n == 3) begin
        chk("R2 done low", int'(done), 0);
        chk("R2 settling high", int'(settling), 1);
        chk("R6 filt_lo cleared", int'(filt_lo), 0);
      end
      if (short_p) begin
        if (n == 3 + w)      chk("R4 filt_lo", int'(filt_lo), 1);
        if (n == 4 + w)      chk("R4 gain=gmax", int'(gain_code), gm);
        if (n == 2 + w + F)  chk("R4 settling held", int'(settling), 1);
        if (n == 3 + w + F) begin
          chk("R4 settling end", int'(settling), 0);
          chk("R4 no done", int'(done), 0);
        end
      end else begin
        if (n == 2 + S) chk("R5 done not yet", int'(done), 0);
        if (n == 3 + S) begin
          chk("R5 R3 done", int'(done), 1);
          chk("R3 settling end", int'(settling), 0);
        end
        if (n == 4 + S) chk("R3 gain capped", int'(gain_code), (lg > gm) ? gm : lg);
      end
    end
    chk("R8 gmax kept", int'(gmax_val), gm);
    gap(3);
  endtask

  task automatic write_gmax(input int v);
    @(negedge clk);
    gmax_we = 1'b1;
    gmax_wdata = GW'(v);
    @(negedge clk);
    gmax_we = 1'b0;
    gm = (v < 54) ? 54 : ((v > 85) ? 85 : v);
    chk("R7 clamp", int'(gmax_val), gm);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    gap(3);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 done", int'(done), 0);
    chk("R1 settling", int'(settling), 0);
    chk("R1 filt_lo", int'(filt_lo), 0);
    chk("R1 gmax", int'(gmax_val), 85);
    chk("R1 gain", int'(gain_code), 85);

    // R7 sweep of every code
    for (int v = 0; v < 128; v++) write_gmax(v);
    write_gmax(85);

    // R4 / R5 width sweep across the short window
    for (int w = 1; w <= 12; w++) run_pulse(w, 100);

    // R3 loop gain sweep against a lowered ceiling
    write_gmax(70);
    for (int lg = 0; lg < 128; lg += 9) run_pulse(20, lg);

    // R10 restart during settle
    @(negedge clk);
    agc_req = 1'b1;
    for (int n = 1; n <= 64; n++) begin
      @(negedge clk);
      if (n == 10) agc_req = 1'b0;
      if (n == 20) agc_req = 1'b1;
      if (n == 43) chk("R10 no early done", int'(done), 0);
      if (n == 62) chk("R10 done still low", int'(done), 0);
      if (n == 63) chk("R10 done after restart", int'(done), 1);
    end
    agc_req = 1'b0;
    gap(3);

    // R11 edges ignored outside receive mode
    rx_mode = 1'b0;
    @(negedge clk);
    agc_req = 1'b1;
    for (int n = 1; n <= 50; n++) begin
      @(negedge clk);
      if (n == 10) agc_req = 1'b0;
      if (n == 5) chk("R11 ignored settling", int'(settling), 0);
    end
    chk("R11 done unchanged", int'(done), 1);
    rx_mode = 1'b1;
    gap(2);
    // R11 abort mid-cycle
    @(negedge clk);
    agc_req = 1'b1;
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (n == 10) rx_mode = 1'b0;
      if (n == 11) begin
        chk("R11 abort settling", int'(settling), 0);
        chk("R11 abort done", int'(done), 0);
      end
    end
    agc_req = 1'b0;
    rx_mode = 1'b1;
    gap(3);

    // R9 manual override above the ceiling
    for (int mg = 60; mg < 128; mg += 17) begin
      @(negedge clk);
      manual_en = 1'b1;
      manual_gain = GW'(mg);
      @(negedge clk);
      chk("R9 manual gain", int'(gain_code), mg);
      chk("R9 R8 gmax kept", int'(gmax_val), gm);
    end
    @(negedge clk);
    manual_en = 1'b0;
    @(negedge clk);
    chk("R9 back to held", int'(gain_code), 70);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule